// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the bus side of an I2C master. It moves one byte per software command. Software loads a byte buffer and writes a control word with four bits:
- a start request;
- a stop request;
- a select that chooses whether the master acknowledges or refuses a received byte;
- a transfer-go bit.

Each command that raises transfer-go runs one byte phase. The phase is an optional START, then eight bits, then the acknowledge clock, then an optional STOP. When the byte is finished the engine drops transfer-go. If no stop was requested, it then holds SCL low as a wait state until software raises transfer-go again.

The first byte after a START is the address byte. Its bit 0 picks the direction for the data bytes that follow: 1 is read and 0 is write. In write direction the engine reports the acknowledge it sampled from the slave and raises a transmit-empty flag. In read direction it places the received byte in the buffer and raises a receive-full flag. The start and stop request bits are never cleared by the engine, so software clears them itself.

The two open-drain lines appear as drive-low enables plus sampled inputs. The register side is a plain write-strobe and status interface with no back-pressure: a write is taken in the cycle it is presented, and status is valid every cycle. While SCL is released in its high half, the engine waits for the sampled line to read high. A slave that stretches the clock therefore lengthens the high half.

Top module: `i2cm_engine`

## Requirements
- R1: A transfer-go command issued while the start request is set, or while the bus is free, produces a START condition. It then shifts the eight buffer bits out MSB first and gives a ninth clock on which the slave acknowledge is sampled.
- R2: `st_tb` is set only by `ctl_we` together with `ctl_tb`=1, and the engine clears it when the byte and its acknowledge clock are finished.
- R3: `st_tx_empty` is 1 after reset. It rises when a master-sent byte completes and falls when software writes `db_we`.
- R4: After a byte that ends without STOP, `scl_oe` stays 1 and no SCL rising edge occurs until transfer-go is set again. The bus stays owned during this time.
- R5: With both start and stop requests at 0, a transfer-go sends one data byte with neither a START nor a STOP on the bus.
- R6: With the stop request at 1, a STOP follows the byte whatever the start request holds. Afterwards both lines are released and `st_bus_own` is 0.
- R7: In write direction, raising stop and transfer-go together sends the final data byte and ends the transfer.
- R8: In read direction the master drives the ninth bit. It pulls SDA low (ACK) when `ctl_nak` was written 0 and leaves SDA released (NAK) when it was written 1. Together with stop, this ends a read.
- R9: The start and stop request bits (`st_start`, `st_stop`) keep their value until the next `ctl_we`.
- R10: A start request issued while the bus is owned gives a repeated START with no STOP before it. Address bit 0 equal to 1 sets `st_rx_mode` to 1 (read).
- R11: Each SCL bit has four quarter phases of `cfg_qdiv`+1 clocks each, so SCL is driven low for exactly 2*(`cfg_qdiv`+1) clocks per bit. SDA changes only while SCL is low, except the fall that forms START and the rise that forms STOP.
- R12: After a master-sent byte, `st_nak_rcvd` holds the sampled acknowledge bit (1 = NAK). After a received byte, `db_rdata` holds the byte MSB first and `st_rx_full` is 1. A buffer write clears `st_rx_full`.
- R13: After reset `scl_oe`=0, `sda_oe`=0, `st_tb`=0, `st_rx_full`=0 and `st_bus_own`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_qdiv | input | QDW | Clocks per SCL quarter phase, minus one (at least 2) |
| db_we | input | 1 | Write strobe for the byte buffer |
| db_wdata | input | 8 | Byte to write into the buffer |
| db_rdata | output | 8 | Byte buffer contents (received byte in read direction) |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_start | input | 1 | Start request bit |
| ctl_stop | input | 1 | Stop request bit |
| ctl_nak | input | 1 | 1 = refuse (NAK) the received byte |
| ctl_tb | input | 1 | 1 = set transfer-go |
| st_tb | output | 1 | Transfer-go pending or running |
| st_start | output | 1 | Stored start request |
| st_stop | output | 1 | Stored stop request |
| st_tx_empty | output | 1 | Sent byte done, buffer may be reloaded |
| st_rx_full | output | 1 | Received byte waiting in buffer |
| st_nak_rcvd | output | 1 | Last sampled slave acknowledge, 1 = NAK |
| st_bus_own | output | 1 | Bus held between START and STOP |
| st_rx_mode | output | 1 | Read direction selected by the last address |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |

## Verification
A bit counter stuck at the wrong value shows on the bus within a single byte. The bus then gives a wrong number of SCL rising edges before `st_tb` drops, and a slave model that counts those edges catches it. A corrupted direction bit shows at the first data byte: either the master and the slave drive SDA together, or the master's ninth bit has the wrong level. A bad phase state shows as an extra START or STOP within a quarter period, because SDA would then move while SCL is high. A lost wait state shows the moment the byte ends, as a rising SCL edge while `st_tb` is still 0.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_BITS  = 3'd2,
    S_STOP  = 3'd3,
    S_HOLD  = 3'd4
  } ph_e;
endpackage

// File: rtl/i2cm_sync.sv
`timescale 1ns/1ps
module i2cm_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/i2cm_qtick.sv
`timescale 1ns/1ps
module i2cm_qtick #(
  parameter int unsigned QDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           stall,
  input  logic [QDW-1:0] qdiv,
  output logic           tick,
  output logic [1:0]     q
);
  logic [QDW-1:0] cnt;

  assign tick = run && !stall && (cnt == qdiv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!stall) begin
      if (cnt == qdiv) begin
        cnt <= '0;
        q   <= q + 2'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_regs.sv
`timescale 1ns/1ps
module i2cm_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          db_we,
  input  logic [DW-1:0] db_wdata,
  input  logic          ctl_we,
  input  logic          ctl_start,
  input  logic          ctl_stop,
  input  logic          ctl_nak,
  input  logic          ctl_tb,
  input  logic          done,
  input  logic          done_tx,
  input  logic          done_ack,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] dbuf,
  output logic          r_start,
  output logic          r_stop,
  output logic          r_nak,
  output logic          r_tb,
  output logic          r_tx_empty,
  output logic          r_rx_full,
  output logic          r_nak_rcvd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbuf       <= '0;
      r_start    <= 1'b0;
      r_stop     <= 1'b0;
      r_nak      <= 1'b0;
      r_tb       <= 1'b0;
      r_tx_empty <= 1'b1;
      r_rx_full  <= 1'b0;
      r_nak_rcvd <= 1'b0;
    end else begin
      if (done) begin
        r_tb <= 1'b0;
        if (done_tx) begin
          r_tx_empty <= 1'b1;
          r_nak_rcvd <= done_ack;
        end else begin
          dbuf      <= rx_byte;
          r_rx_full <= 1'b1;
        end
      end
      if (ctl_we) begin
        r_start <= ctl_start;
        r_stop  <= ctl_stop;
        r_nak   <= ctl_nak;
        if (ctl_tb) begin
          r_tb      <= 1'b1;
          r_rx_full <= 1'b0;
        end
      end
      if (db_we) begin
        dbuf       <= db_wdata;
        r_tx_empty <= 1'b0;
        r_rx_full  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    q,
  input  logic          tb,
  input  logic          start,
  input  logic          stop,
  input  logic          nak,
  input  logic [DW-1:0] dbuf,
  input  logic          sda_s,
  output ph_e           ph,
  output logic          run,
  output logic          scl_low,
  output logic          sda_upd,
  output logic          sda_val,
  output logic          done,
  output logic          done_tx,
  output logic          done_ack,
  output logic [DW-1:0] rx_byte,
  output logic          own,
  output logic          rx_mode
);
  localparam int unsigned CW = $clog2(DW + 1);

  ph_e           st;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] sh;
  logic          rep, is_tx, ack_s, own_q, rxm_q;
  logic          kick, new_start, last_bit;

  assign kick      = tb && ((st == S_IDLE) || (st == S_HOLD));
  assign new_start = start || !own_q;
  assign last_bit  = (bcnt == CW'(DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      bcnt  <= '0;
      sh    <= '0;
      rep   <= 1'b0;
      is_tx <= 1'b0;
      ack_s <= 1'b0;
      own_q <= 1'b0;
      rxm_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_HOLD: begin
          if (kick) begin
            sh   <= dbuf;
            bcnt <= '0;
            if (new_start) begin
              st    <= S_START;
              rep   <= own_q;
              own_q <= 1'b1;
              is_tx <= 1'b1;
              rxm_q <= dbuf[0];
            end else begin
              st    <= S_BITS;
              is_tx <= !rxm_q;
            end
          end
        end
        S_START: if (tick && q == 2'd3) st <= S_BITS;
        S_BITS: begin
          if (tick && q == 2'd2) begin
            if (!last_bit) sh <= {sh[DW-2:0], sda_s};
            else           ack_s <= sda_s;
          end
          if (tick && q == 2'd3) begin
            if (last_bit) st <= stop ? S_STOP : S_HOLD;
            else          bcnt <= bcnt + 1'b1;
          end
        end
        S_STOP: begin
          if (tick && q == 2'd3) begin
            st    <= S_IDLE;
            own_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_upd = 1'b0;
    sda_val = 1'b0;
    case (st)
      S_IDLE: sda_upd = 1'b1;
      S_HOLD: scl_low = 1'b1;
      S_START: begin
        scl_low = rep && !q[1];
        sda_upd = (q == 2'd1) || (q == 2'd3);
        sda_val = (q == 2'd3);
      end
      S_BITS: begin
        scl_low = !q[1];
        sda_upd = (q == 2'd1);
        sda_val = last_bit ? (!is_tx && !nak) : (is_tx && !sh[DW-1]);
      end
      S_STOP: begin
        scl_low = !q[1];
        sda_upd = (q == 2'd1) || (q == 2'd3);
        sda_val = (q == 2'd1);
      end
      default: ;
    endcase
  end

  assign ph       = st;
  assign run      = (st == S_START) || (st == S_BITS) || (st == S_STOP);
  assign done     = (st == S_BITS) && tick && (q == 2'd3) && last_bit;
  assign done_tx  = is_tx;
  assign done_ack = ack_s;
  assign rx_byte  = sh;
  assign own      = own_q;
  assign rx_mode  = rxm_q;
endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int unsigned QDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [QDW-1:0] cfg_qdiv,
  input  logic           db_we,
  input  logic [7:0]     db_wdata,
  output logic [7:0]     db_rdata,
  input  logic           ctl_we,
  input  logic           ctl_start,
  input  logic           ctl_stop,
  input  logic           ctl_nak,
  input  logic           ctl_tb,
  output logic           st_tb,
  output logic           st_start,
  output logic           st_stop,
  output logic           st_tx_empty,
  output logic           st_rx_full,
  output logic           st_nak_rcvd,
  output logic           st_bus_own,
  output logic           st_rx_mode,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           scl_oe,
  output logic           sda_oe
);
  localparam int unsigned DW = BYTE_W;

  logic          scl_s, sda_s, stall, tick, run;
  logic [1:0]    q;
  logic          r_nak, scl_low, sda_upd, sda_val;
  logic          done, done_tx, done_ack;
  logic [DW-1:0] rx_byte;
  ph_e           ph, ph_q;

  i2cm_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout({scl_s, sda_s})
  );

  assign stall = !scl_oe && !scl_s && (ph != S_IDLE);

  i2cm_qtick #(.QDW(QDW)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(run), .stall(stall), .qdiv(cfg_qdiv),
    .tick(tick), .q(q)
  );

  i2cm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .db_we(db_we), .db_wdata(db_wdata),
    .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
    .ctl_nak(ctl_nak), .ctl_tb(ctl_tb), .done(done), .done_tx(done_tx),
    .done_ack(done_ack), .rx_byte(rx_byte), .dbuf(db_rdata),
    .r_start(st_start), .r_stop(st_stop), .r_nak(r_nak), .r_tb(st_tb),
    .r_tx_empty(st_tx_empty), .r_rx_full(st_rx_full), .r_nak_rcvd(st_nak_rcvd)
  );

  i2cm_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .q(q), .tb(st_tb),
    .start(st_start), .stop(st_stop), .nak(r_nak), .dbuf(db_rdata),
    .sda_s(sda_s), .ph(ph), .run(run), .scl_low(scl_low),
    .sda_upd(sda_upd), .sda_val(sda_val), .done(done), .done_tx(done_tx),
    .done_ack(done_ack), .rx_byte(rx_byte), .own(st_bus_own),
    .rx_mode(st_rx_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      ph_q   <= S_IDLE;
    end else begin
      scl_oe <= scl_low;
      if (sda_upd) sda_oe <= sda_val;
      ph_q   <= ph;
    end
  end
endmodule

// File: rtl/i2cm_engine_chk.sv
`timescale 1ns/1ps
module i2cm_engine_chk
  import i2cm_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic ctl_we,
  input logic ctl_tb,
  input logic db_we,
  input logic st_tb,
  input logic st_start,
  input logic st_stop,
  input logic st_rx_full,
  input logic scl_oe,
  input logic sda_oe,
  input ph_e  ph,
  input ph_e  ph_q,
  input logic done,
  input logic done_tx
);
  AST_TB_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(ctl_we && ctl_tb)) |=> !st_tb); // R2
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_HOLD) |=> scl_oe); // R4
  AST_START_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_start && !ctl_we) |=> st_start); // R9
  AST_STOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_stop && !ctl_we) |=> st_stop); // R9
  AST_SDA_FALL_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (ph_q == S_START)); // R11
  AST_SDA_RISE_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> (ph_q == S_STOP)); // R11
  AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_tx && !db_we) |=> st_rx_full); // R12
endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_tb(ctl_tb), .db_we(db_we),
  .st_tb(st_tb), .st_start(st_start), .st_stop(st_stop),
  .st_rx_full(st_rx_full), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ph(ph), .ph_q(ph_q), .done(done), .done_tx(done_tx)
);

// File: tb/i2cm_engine_tb.sv
`timescale 1ns/1ps
module i2cm_engine_tb;
  localparam int QDW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [QDW-1:0] cfg_qdiv = 8'd3;
  logic db_we = 0, ctl_we = 0, ctl_start = 0, ctl_stop = 0, ctl_nak = 0, ctl_tb = 0;
  logic [7:0] db_wdata = 8'h00, db_rdata;
  logic st_tb, st_start, st_stop, st_tx_empty, st_rx_full, st_nak_rcvd, st_bus_own, st_rx_mode;
  logic scl_i, sda_i, scl_oe, sda_oe;

  logic s_sda_low = 1'b0;
  logic bus_scl, bus_sda;
  assign bus_scl = ~scl_oe;
  assign bus_sda = ~sda_oe & ~s_sda_low;
  assign scl_i = bus_scl;
  assign sda_i = bus_sda;

  i2cm_engine #(.QDW(QDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_qdiv(cfg_qdiv), .db_we(db_we), .db_wdata(db_wdata),
    .db_rdata(db_rdata), .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
    .ctl_nak(ctl_nak), .ctl_tb(ctl_tb), .st_tb(st_tb), .st_start(st_start),
    .st_stop(st_stop), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .st_nak_rcvd(st_nak_rcvd), .st_bus_own(st_bus_own), .st_rx_mode(st_rx_mode),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // slave model and bus monitor
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic slv_ack = 1'b1;
  int n_start = 0, n_stop = 0, n_rise = 0, nwr = 0, bitn = 0, rd_idx = 0;
  logic is_addr = 1'b0, rd = 1'b0, s_tx = 1'b0, last_ack = 1'b0;
  logic [7:0] sh = 8'h00, got_addr = 8'h00;
  logic [7:0] wr_log [8];
  logic [7:0] rd_bytes [4];
  int lowcnt = 0, last_low = 0;

  initial begin
    rd_bytes[0] = 8'h5A; rd_bytes[1] = 8'h96; rd_bytes[2] = 8'h00; rd_bytes[3] = 8'h00;
    for (int i = 0; i < 8; i++) wr_log[i] = 8'h00;
  end

  always @(posedge clk) begin
    p_scl <= bus_scl;
    p_sda <= bus_sda;
    if (scl_oe) lowcnt <= lowcnt + 1;
    else if (lowcnt != 0) begin last_low <= lowcnt; lowcnt <= 0; end
    if (bus_scl && p_scl && p_sda && !bus_sda) begin
      n_start <= n_start + 1; bitn <= 0; is_addr <= 1'b1; s_sda_low <= 1'b0; s_tx <= 1'b0;
    end else if (bus_scl && p_scl && !p_sda && bus_sda) begin
      n_stop <= n_stop + 1; s_sda_low <= 1'b0; s_tx <= 1'b0;
    end else if (bus_scl && !p_scl) begin
      n_rise <= n_rise + 1;
      if (bitn < 8) begin
        sh <= {sh[6:0], bus_sda}; bitn <= bitn + 1;
      end else begin
        last_ack <= bus_sda; bitn <= 0;
        if (is_addr) begin
          got_addr <= sh; is_addr <= 1'b0; rd <= sh[0];
          s_tx <= sh[0] && slv_ack; rd_idx <= 0;
        end else if (!rd) begin
          wr_log[nwr] <= sh; nwr <= nwr + 1;
        end else begin
          if (bus_sda) s_tx <= 1'b0;
          rd_idx <= rd_idx + 1;
        end
      end
    end else if (!bus_scl && p_scl) begin
      if (bitn == 8) s_sda_low <= (is_addr || !rd) ? slv_ack : 1'b0;
      else           s_sda_low <= s_tx ? !rd_bytes[rd_idx][7-bitn] : 1'b0;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic db_write(input logic [7:0] v);
    @(negedge clk); db_we = 1; db_wdata = v;
    @(negedge clk); db_we = 0;
  endtask

  task automatic ctl_write(input logic s, input logic p, input logic n, input logic t);
    @(negedge clk); ctl_we = 1; ctl_start = s; ctl_stop = p; ctl_nak = n; ctl_tb = t;
    @(negedge clk); ctl_we = 0; ctl_tb = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (st_tb && k < 20000) begin @(negedge clk); k++; end
    chk(!st_tb, "R2 tb self clear", st_tb, 0);
  endtask

  task automatic wait_free();
    int k = 0;
    while (st_bus_own && k < 20000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!scl_oe && !sda_oe, "R13 lines released", {scl_oe, sda_oe}, 0);
    chk(!st_tb && !st_rx_full && !st_bus_own, "R13 flags clear", {st_tb, st_rx_full, st_bus_own}, 0);
    chk(st_tx_empty, "R3 tx_empty after reset", st_tx_empty, 1);
  endtask

  task automatic t_write();
    int s0 = n_start, p0 = n_stop, r0;
    db_write(8'hA0);
    ctl_write(1, 0, 0, 1);
    wait_done();
    chk(n_start == s0 + 1, "R1 start generated", n_start - s0, 1);
    chk(got_addr == 8'hA0, "R1 address byte", got_addr, 8'hA0);
    chk(st_tx_empty, "R3 tx_empty on byte done", st_tx_empty, 1);
    chk(!st_nak_rcvd, "R12 ack latched", st_nak_rcvd, 0);
    chk(st_start, "R9 start kept", st_start, 1);
    chk(last_low == 8, "R11 scl low width div3", last_low, 8);
    chk(!st_rx_mode, "R10 write direction", st_rx_mode, 0);
    r0 = n_rise;
    repeat (300) @(negedge clk);
    chk(scl_oe && st_bus_own && n_rise == r0, "R4 wait state holds scl", n_rise - r0, 0);
    db_write(8'h3C);
    chk(!st_tx_empty, "R3 tx_empty cleared by write", st_tx_empty, 0);
    ctl_write(0, 0, 0, 1);
    wait_done();
    chk(nwr == 1 && wr_log[0] == 8'h3C, "R5 data byte", wr_log[0], 8'h3C);
    chk(n_start == s0 + 1 && n_stop == p0, "R5 no start or stop", n_start - s0, 1);
    db_write(8'hC5);
    ctl_write(0, 1, 0, 1);
    wait_done();
    wait_free();
    chk(nwr == 2 && wr_log[1] == 8'hC5, "R7 last byte", wr_log[1], 8'hC5);
    chk(n_stop == p0 + 1, "R7 stop after last byte", n_stop - p0, 1);
    chk(!scl_oe && !sda_oe && !st_bus_own, "R6 bus released", {scl_oe, sda_oe, st_bus_own}, 0);
    chk(st_stop, "R9 stop kept", st_stop, 1);
    ctl_write(0, 0, 0, 0);
    repeat (100) @(negedge clk);
    chk(!st_tb && !scl_oe && n_start == s0 + 1, "R2 no go without tb", st_tb, 0);
  endtask

  task automatic t_read();
    int p0 = n_stop;
    db_write(8'hA1);
    ctl_write(1, 0, 0, 1);
    wait_done();
    chk(st_rx_mode, "R10 read direction", st_rx_mode, 1);
    ctl_write(0, 0, 0, 1);
    wait_done();
    chk(st_rx_full && db_rdata == 8'h5A, "R12 first rx byte", db_rdata, 8'h5A);
    chk(last_ack == 1'b0, "R8 master ack", last_ack, 0);
    ctl_write(0, 1, 1, 1);
    wait_done();
    wait_free();
    chk(db_rdata == 8'h96, "R12 last rx byte", db_rdata, 8'h96);
    chk(last_ack == 1'b1, "R8 master nak", last_ack, 1);
    chk(n_stop == p0 + 1, "R8 read ends with stop", n_stop - p0, 1);
    db_write(8'h00);
    chk(!st_rx_full, "R12 rx_full cleared by write", st_rx_full, 0);
    ctl_write(0, 0, 0, 0);
  endtask

  task automatic t_nak_start_stop();
    int s0 = n_start, p0 = n_stop;
    slv_ack = 1'b0;
    db_write(8'hB0);
    ctl_write(1, 1, 0, 1);
    wait_done();
    wait_free();
    chk(st_nak_rcvd, "R12 nak latched", st_nak_rcvd, 1);
    chk(n_start == s0 + 1 && n_stop == p0 + 1, "R6 stop with start set", n_stop - p0, 1);
    slv_ack = 1'b1;
    ctl_write(0, 0, 0, 0);
  endtask

  task automatic t_rstart();
    int s0 = n_start, p0 = n_stop;
    db_write(8'hA0);
    ctl_write(1, 0, 0, 1);
    wait_done();
    db_write(8'hA1);
    ctl_write(1, 0, 0, 1);
    wait_done();
    chk(n_start == s0 + 2 && n_stop == p0, "R10 repeated start", n_start - s0, 2);
    chk(got_addr == 8'hA1 && st_rx_mode, "R10 read address", got_addr, 8'hA1);
    ctl_write(0, 1, 1, 1);
    wait_done();
    wait_free();
    chk(db_rdata == 8'h5A && n_stop == p0 + 1, "R8 read after repeated start", db_rdata, 8'h5A);
    ctl_write(0, 0, 0, 0);
  endtask

  task automatic t_div();
    cfg_qdiv = 8'd5;
    db_write(8'h42);
    ctl_write(1, 1, 0, 1);
    wait_done();
    chk(last_low == 12, "R11 scl low width div5", last_low, 12);
    wait_free();
    ctl_write(0, 0, 0, 0);
    cfg_qdiv = 8'd3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_nak_start_stop();
    t_rstart();
    t_div();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule